// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block services the transmit side of an Ethernet controller. Software builds a chain of descriptors in memory, each pointing at one fragment of a frame. It loads the address of the first descriptor and then pulses a start input, which stands for a write of the DMA-enable bit. The walker then follows the chain. For every descriptor that the hardware owns, it copies the fragment into an on-chip staging buffer and hands the descriptor back to software by clearing its ownership bit. When the fragment marked last has been staged, it sends the whole frame as a byte stream with a last flag.

A walk ends at the first descriptor that software still holds. It also ends when a fragment would push the frame past the staging limit. In that case the error is recorded in that descriptor's status word. When a walk has sent at least one frame, it pulses a transmit-done interrupt-status set line and a line that clears the DMA-start control bit. The address of the descriptor being worked on is always visible on an output.

The controller is an FSM with these states:

- IDLE waits for a start pulse. While waiting it takes new base addresses.
- FETCH reads the four descriptor words.
- JUDGE decides what happens next:
  - it goes to WRAP if the descriptor is not owned;
  - it goes to FAULT if the fragment does not fit;
  - it goes to RELEASE if the fragment length is zero;
  - otherwise it goes to RDBUF.
- RDBUF reads one buffer word.
- PACK moves the bytes of that word into staging, one per cycle. It goes back to RDBUF after a full word, or to RELEASE when the fragment is done.
- RELEASE writes the status word back. It goes to EMIT after a last fragment of a non-empty frame, and to ADVANCE otherwise.
- EMIT streams the staged frame, then goes to ADVANCE.
- ADVANCE follows the next pointer back to FETCH.
- FAULT writes the error status, then goes to WRAP.
- WRAP raises the completion pulses for one cycle and returns to IDLE.

Top module: `tx_desc_walker`

## Requirements
- R1: After reset, `m_tvalid`, `mem_req`, `done_set` and `start_clr` are low and `cur_desc` is zero.
- R2: A `base_wr` pulse while the walker is idle loads `base_addr` into the current pointer, and `cur_desc` shows it after the next clock edge.
- R3: A descriptor is four 32-bit words at offsets 0, 4, 8 and 12: status, control, buffer address and next-descriptor address. It is owned by the hardware only while status bit 31 is set. A walk stops at the first descriptor that is not owned and leaves `cur_desc` pointing at it.
- R4: Control bits 10:0 give the fragment length in bytes, and control bit 30 marks the last fragment of a frame. The frame is the concatenation of its fragments in chain order. Within each word-aligned buffer, bytes go out in rising address order, with bits 7:0 of a word first.
- R5: `m_tlast` is high only on the final byte of a frame. While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold.
- R6: Once a fragment is consumed, its status word is written back to the descriptor address with bit 31 cleared and every other bit unchanged. The next pointer is followed only after that write.
- R7: If the staged length plus a fragment would exceed 2048 bytes, that descriptor's status is written back with bit 14 set and bit 31 left set. The walk then stops, no byte of that frame is sent, and `cur_desc` stays on that descriptor. A frame of exactly 2048 bytes is sent normally.
- R8: A fragment of length 0 is released with no data read or sent. A last fragment that closes a frame with no bytes sends nothing and does not count as a frame.
- R9: At the end of a walk that sent at least one frame, `done_set` and `start_clr` are high together for exactly one cycle. A walk that sent no frame raises neither.
- R10: Bytes staged for a frame whose last fragment was not reached before the walk stopped are dropped. Nothing of that frame is sent.
- R11: `mem_req` stays high, with `mem_addr` and `mem_we` stable, until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr | input | 1 | Load pulse for the descriptor list base |
| base_addr | input | AW | Descriptor list base address |
| start | input | 1 | Start-walk pulse (DMA-enable write) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completion |
| m_tdata | output | 8 | Frame byte |
| m_tvalid | output | 1 | Byte valid |
| m_tready | input | 1 | Sink ready |
| m_tlast | output | 1 | Final byte of frame |
| done_set | output | 1 | Transmit-done interrupt-status set pulse |
| start_clr | output | 1 | Clear pulse for the DMA-start control bit |
| cur_desc | output | AW | Address of the current descriptor |

## Verification
The new pointer is due on `cur_desc` one clock edge after `base_wr`, and it is checked at the falling edge that follows. Stream bytes and the one-cycle completion pulses come at times that depend on memory latency, so monitors log every handshake and every pulse on the rising edges. The directed tasks compare those logs only after the walker has shown no request and no valid data for ten falling edges in a row. At that point the written-back descriptor words in the memory model and `cur_desc` are also settled and can be compared.

// File: rtl/txw_pkg.sv
package txw_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_JUDGE, S_RDBUF, S_PACK,
        S_RELEASE, S_EMIT, S_ADVANCE, S_FAULT, S_WRAP
    } walk_state_e;

    localparam int OWN_BIT  = 31;
    localparam int LAST_BIT = 30;
    localparam int LERR_BIT = 14;
    localparam int FLEN_W   = 11;
endpackage

// File: rtl/txw_stage.sv
module txw_stage #(
    parameter int DEPTH = 2048,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_byte,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_byte
);
    logic [7:0] bytes_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) bytes_q[wr_idx] <= wr_byte;
    end

    assign rd_byte = bytes_q[rd_idx];
endmodule

// File: rtl/tx_desc_walker.sv
module tx_desc_walker
    import txw_pkg::*;
#(
    parameter int AW        = 32,
    parameter int MAX_FRAME = 2048
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_wr,
    input  logic [AW-1:0] base_addr,
    input  logic          start,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    output logic [7:0]    m_tdata,
    output logic          m_tvalid,
    input  logic          m_tready,
    output logic          m_tlast,
    output logic          done_set,
    output logic          start_clr,
    output logic [AW-1:0] cur_desc
);
    localparam int FLW = $clog2(MAX_FRAME + 1);
    localparam int SIW = $clog2(MAX_FRAME);

    walk_state_e       state;
    logic [1:0]        widx;
    logic [31:0]       d_stat, d_ctrl, d_next;
    logic [AW-1:0]     d_buf;
    logic [FLW-1:0]    frame_len, sidx;
    logic [FLEN_W-1:0] done_b;
    logic [31:0]       word_q;
    logic              sent_any;

    logic [FLEN_W-1:0] frag_len;
    logic [FLW:0]      sum_len;
    logic              stg_we;
    logic [7:0]        stg_wbyte;

    assign frag_len = d_ctrl[FLEN_W-1:0];
    assign sum_len  = {1'b0, frame_len} + (FLW+1)'(frag_len);

    txw_stage #(.DEPTH(MAX_FRAME)) u_stage (
        .clk     (clk),
        .wr_en   (stg_we),
        .wr_idx  (frame_len[SIW-1:0]),
        .wr_byte (stg_wbyte),
        .rd_idx  (sidx[SIW-1:0]),
        .rd_byte (m_tdata)
    );

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cur_desc  <= '0;
            widx      <= '0;
            d_stat    <= '0;
            d_ctrl    <= '0;
            d_buf     <= '0;
            d_next    <= '0;
            frame_len <= '0;
            sidx      <= '0;
            done_b    <= '0;
            word_q    <= '0;
            sent_any  <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        widx      <= '0;
                        frame_len <= '0;
                        sent_any  <= 1'b0;
                        state     <= S_FETCH;
                    end else if (base_wr) begin
                        cur_desc <= base_addr;
                    end
                end
                S_FETCH: begin
                    if (mem_ack) begin
                        unique case (widx)
                            2'd0: d_stat <= mem_rdata;
                            2'd1: d_ctrl <= mem_rdata;
                            2'd2: d_buf  <= AW'(mem_rdata);
                            2'd3: d_next <= mem_rdata;
                        endcase
                        widx <= widx + 2'd1;
                        if (widx == 2'd3) state <= S_JUDGE;
                    end
                end
                S_JUDGE: begin
                    if (!d_stat[OWN_BIT])                       state <= S_WRAP;
                    else if (sum_len > (FLW+1)'(MAX_FRAME))     state <= S_FAULT;
                    else if (frag_len == '0)                    state <= S_RELEASE;
                    else begin
                        done_b <= '0;
                        state  <= S_RDBUF;
                    end
                end
                S_RDBUF: begin
                    if (mem_ack) begin
                        word_q <= mem_rdata;
                        state  <= S_PACK;
                    end
                end
                S_PACK: begin
                    frame_len <= frame_len + 1'b1;
                    done_b    <= done_b + 1'b1;
                    if (done_b + 1'b1 == frag_len) state <= S_RELEASE;
                    else if (done_b[1:0] == 2'd3)  state <= S_RDBUF;
                end
                S_RELEASE: begin
                    if (mem_ack) begin
                        if (d_ctrl[LAST_BIT] && frame_len != '0) begin
                            sidx  <= '0;
                            state <= S_EMIT;
                        end else begin
                            state <= S_ADVANCE;
                        end
                    end
                end
                S_EMIT: begin
                    if (m_tready) begin
                        if (sidx == frame_len - 1'b1) begin
                            sent_any  <= 1'b1;
                            frame_len <= '0;
                            state     <= S_ADVANCE;
                        end else begin
                            sidx <= sidx + 1'b1;
                        end
                    end
                end
                S_ADVANCE: begin
                    cur_desc <= AW'(d_next);
                    widx     <= '0;
                    state    <= S_FETCH;
                end
                S_FAULT:   if (mem_ack) state <= S_WRAP;
                S_WRAP:    state <= S_IDLE;
                default:   state <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_desc;
        mem_wdata = d_stat;
        m_tvalid  = 1'b0;
        m_tlast   = 1'b0;
        done_set  = 1'b0;
        start_clr = 1'b0;
        stg_we    = 1'b0;
        stg_wbyte = word_q[8*done_b[1:0] +: 8];
        unique case (state)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_desc + AW'({widx, 2'b00});
            end
            S_RDBUF: begin
                mem_req  = 1'b1;
                mem_addr = d_buf + AW'({done_b[FLEN_W-1:2], 2'b00});
            end
            S_PACK: stg_we = 1'b1;
            S_RELEASE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = d_stat & ~(32'd1 << OWN_BIT);
            end
            S_FAULT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = d_stat | (32'd1 << LERR_BIT);
            end
            S_EMIT: begin
                m_tvalid = 1'b1;
                m_tlast  = (sidx == frame_len - 1'b1);
            end
            S_WRAP: begin
                done_set  = sent_any;
                start_clr = sent_any;
            end
            default: ;
        endcase
    end

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R5
    stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

    // R7
    stage_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_len <= FLW'(MAX_FRAME));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> !done_set);
endmodule

// File: tb/tb_tx_desc_walker.sv
module tb_tx_desc_walker;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          base_wr = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          start = 1'b0;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic [7:0]    m_tdata;
    logic          m_tvalid, m_tlast;
    logic          m_tready = 1'b1;
    logic          done_set, start_clr;
    logic [AW-1:0] cur_desc;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_desc_walker #(.AW(AW), .MAX_FRAME(2048)) dut (
        .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_addr(base_addr),
        .start(start), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tlast(m_tlast), .done_set(done_set), .start_clr(start_clr),
        .cur_desc(cur_desc)
    );

    // descriptor memory below 0x1000, computed buffer contents above
    logic [31:0] dmem [1024];
    logic        h_we = 1'b0;
    logic [9:0]  h_idx = '0;
    logic [31:0] h_data = '0;

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_addr < 32'h1000) begin
                    if (mem_we) dmem[mem_addr[11:2]] <= mem_wdata;
                    else mem_rdata <= dmem[mem_addr[11:2]];
                end else begin
                    mem_rdata <= {pat(mem_addr + 3), pat(mem_addr + 2),
                                  pat(mem_addr + 1), pat(mem_addr)};
                end
            end
        end
        if (h_we) dmem[h_idx] <= h_data;
    end

    // backpressure
    int bp_mode = 0;
    int rdy_cnt = 0;
    always @(negedge clk) begin
        rdy_cnt <= rdy_cnt + 1;
        m_tready <= (bp_mode == 0) ? 1'b1 : ((rdy_cnt % 3) != 0);
    end

    // monitors
    logic [7:0] cap_d [8192];
    logic       cap_l [8192];
    int ncap = 0, n_done = 0, n_clr = 0;
    always @(posedge clk) begin
        if (rst_n && m_tvalid && m_tready) begin
            cap_d[ncap] <= m_tdata;
            cap_l[ncap] <= m_tlast;
            ncap <= ncap + 1;
        end
        if (rst_n && done_set)  n_done <= n_done + 1;
        if (rst_n && start_clr) n_clr  <= n_clr + 1;
    end

    int total = 0, bad = 0;
    int cycles = 0;
    logic [7:0] exp_d [8192];
    int exp_n = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_word(input logic [31:0] a, input logic [31:0] v);
        @(negedge clk);
        h_we = 1'b1; h_idx = a[11:2]; h_data = v;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic mk_desc(input logic [31:0] a, input logic [31:0] st,
                           input logic [31:0] ctl, input logic [31:0] buf_a,
                           input logic [31:0] nxt);
        put_word(a, st);
        put_word(a + 4, ctl);
        put_word(a + 8, buf_a);
        put_word(a + 12, nxt);
    endtask

    task automatic add_exp(input logic [31:0] a, input int len);
        for (int i = 0; i < len; i++) begin
            exp_d[exp_n] = pat(a + i);
            exp_n++;
        end
    endtask

    task automatic load_base(input logic [31:0] a);
        @(negedge clk);
        base_wr = 1'b1; base_addr = a;
        @(negedge clk);
        base_wr = 1'b0;
        chk(cur_desc == a, "R2 base load", cur_desc, a);
    endtask

    task automatic run_walk();
        int quiet = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 40000 && quiet < 10; i++) begin
            @(negedge clk);
            if (mem_req || m_tvalid) quiet = 0;
            else quiet++;
        end
    endtask

    // compare bytes captured since base with exp_d; lasts at given positions
    task automatic cmp_stream(input int base, input string tag, input int l0, input int l1);
        int mism = 0;
        int lastbad = 0;
        chk(ncap - base == exp_n, {tag, " byte count"}, ncap - base, exp_n);
        for (int i = 0; i < exp_n && base + i < ncap; i++) begin
            if (cap_d[base + i] !== exp_d[i]) mism++;
            if (cap_l[base + i] !== ((i == l0) || (i == l1))) lastbad++;
        end
        chk(mism == 0, {tag, " byte mismatches"}, mism, 0);
        chk(lastbad == 0, {tag, " tlast placement"}, lastbad, 0);
    endtask

    task automatic t_reset();
        chk(m_tvalid == 1'b0, "R1 tvalid", m_tvalid, 0);
        chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
        chk(done_set == 1'b0 && start_clr == 1'b0, "R1 pulses", done_set, 0);
        chk(cur_desc == '0, "R1 cur_desc", cur_desc, 0);
    endtask

    task automatic t_single();
        int b = ncap, d = n_done;
        mk_desc(32'h100, 32'h8000_0003, 32'h6000_0006, 32'h1000, 32'h110);
        mk_desc(32'h110, 32'h0000_0000, 32'h6000_0004, 32'h1100, 32'h100);
        exp_n = 0;
        add_exp(32'h1000, 6);
        load_base(32'h100);
        run_walk();
        cmp_stream(b, "R4 single frame", 5, -1);
        chk(dmem[32'h100 >> 2] == 32'h0000_0003, "R6 release keeps other bits", dmem[32'h100 >> 2], 32'h3);
        chk(cur_desc == 32'h110, "R3 stop at unowned", cur_desc, 32'h110);
        chk(n_done - d == 1, "R9 done pulse", n_done - d, 1);
        chk(n_clr == n_done, "R9 start clear", n_clr, n_done);
    endtask

    task automatic t_chain();
        int b = ncap, d = n_done;
        bp_mode = 1;
        mk_desc(32'h200, 32'h8000_0000, 32'h2000_0003, 32'h1100, 32'h210);
        mk_desc(32'h210, 32'h8000_0000, 32'h0000_0000, 32'h1180, 32'h220);
        mk_desc(32'h220, 32'h8000_0000, 32'h0000_0007, 32'h1200, 32'h230);
        mk_desc(32'h230, 32'h8000_0000, 32'h4000_0002, 32'h1300, 32'h240);
        mk_desc(32'h240, 32'h8000_0000, 32'h6000_0001, 32'h1400, 32'h250);
        mk_desc(32'h250, 32'h0000_0000, 32'h6000_0001, 32'h1400, 32'h200);
        exp_n = 0;
        add_exp(32'h1100, 3);
        add_exp(32'h1200, 7);
        add_exp(32'h1300, 2);
        add_exp(32'h1400, 1);
        load_base(32'h200);
        run_walk();
        bp_mode = 0;
        cmp_stream(b, "R5 chained frames with backpressure", 11, 12);
        chk(dmem[32'h210 >> 2] == 32'h0, "R8 zero length released", dmem[32'h210 >> 2], 0);
        chk(dmem[32'h230 >> 2] == 32'h0, "R6 middle release", dmem[32'h230 >> 2], 0);
        chk(cur_desc == 32'h250, "R3 chain end", cur_desc, 32'h250);
        chk(n_done - d == 1, "R9 one pulse per walk", n_done - d, 1);
    endtask

    task automatic t_full();
        int b = ncap, d = n_done;
        mk_desc(32'h300, 32'h8000_0000, 32'h2000_07ff, 32'h2000, 32'h310);
        mk_desc(32'h310, 32'h8000_0000, 32'h4000_0001, 32'h3000, 32'h320);
        mk_desc(32'h320, 32'h0000_0000, 32'h0, 32'h0, 32'h300);
        exp_n = 0;
        add_exp(32'h2000, 2047);
        add_exp(32'h3000, 1);
        load_base(32'h300);
        run_walk();
        cmp_stream(b, "R7 exactly 2048 bytes", 2047, -1);
        chk(n_done - d == 1, "R9 full frame done", n_done - d, 1);
    endtask

    task automatic t_overflow();
        int b = ncap, d = n_done;
        mk_desc(32'h400, 32'h8000_0000, 32'h2000_07d0, 32'h2000, 32'h410);
        mk_desc(32'h410, 32'h8000_0000, 32'h4000_0064, 32'h3000, 32'h420);
        mk_desc(32'h420, 32'h8000_0000, 32'h6000_0001, 32'h1400, 32'h430);
        mk_desc(32'h430, 32'h0000_0000, 32'h0, 32'h0, 32'h400);
        load_base(32'h400);
        run_walk();
        chk(ncap == b, "R7 no bytes on overflow", ncap - b, 0);
        chk(dmem[32'h410 >> 2] == 32'h8000_4000, "R7 error status", dmem[32'h410 >> 2], 32'h8000_4000);
        chk(dmem[32'h400 >> 2] == 32'h0, "R6 first fragment released", dmem[32'h400 >> 2], 0);
        chk(dmem[32'h420 >> 2] == 32'h8000_0000, "R7 walk stopped", dmem[32'h420 >> 2], 32'h8000_0000);
        chk(cur_desc == 32'h410, "R7 pointer on failing desc", cur_desc, 32'h410);
        chk(n_done == d, "R9 no done without frame", n_done - d, 0);
    endtask

    task automatic t_partial();
        int b = ncap, d = n_done;
        mk_desc(32'h500, 32'h8000_0000, 32'h2000_0004, 32'h1500, 32'h510);
        mk_desc(32'h510, 32'h0000_0000, 32'h4000_0004, 32'h1600, 32'h500);
        load_base(32'h500);
        run_walk();
        chk(ncap == b, "R10 partial frame dropped", ncap - b, 0);
        chk(dmem[32'h500 >> 2] == 32'h0, "R10 fragment released", dmem[32'h500 >> 2], 0);
        chk(n_done == d, "R10 no done", n_done - d, 0);
        run_walk();
        chk(ncap == b && n_done == d, "R3 nothing owned", ncap - b, 0);
        chk(cur_desc == 32'h510, "R3 pointer unchanged", cur_desc, 32'h510);
    endtask

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) dmem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_chain();
        t_full();
        t_overflow();
        t_partial();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule